// File: doc/BRIEF.md
# Multi-Source Reset Supervisor Sequencer

This block turns several digitised supply-fault flags and a push-button input into one active-low system reset. Each supply channel delivers a flag that is high while its rail sits below threshold; a per-channel enable mask removes unused channels, so two-monitor and three-monitor variants share one netlist. The button input is active low. In the direct mode it passes through a short glitch filter. In the delayed mode it must be held for a programmable time before it counts as a request.

Reset asserts as soon as any enabled source is bad. It is released only after every source has stayed good for a whole recovery window. A two-bit select picks one of three window lengths, which are set in microseconds and converted to clock cycles from a clock-frequency parameter. Any disturbance during the window sends the sequencer back to the asserted state, and the count starts again from zero. The output pair models either a push-pull pin (always driven) or an open-drain pin (driven low or released).

Top module: `reset_sequencer`

## Requirements
- R1: A high flag on an enabled channel of `faultIn` drives reset active (rstN low in push-pull mode) within 10 clock cycles. This is far inside a 20 µs limit.
- R2: Reset is released only after every enabled flag is low and `mrN` is high. The release comes no earlier than the selected recovery length, measured from the cycle in which the last source went good, and no more than 8 cycles after that length.
- R3: `recSel` picks the recovery length: 0 gives REC0_US, 1 gives REC1_US, and both 2 and 3 give REC2_US. Each is converted to CLK_HZ/1e6 cycles per µs.
- R4: With `delayMode` = 0, a low pulse on `mrN` shorter than GLITCH_CYC = ceil(100 ns · CLK_HZ) cycles (25 at 250 MHz) has no effect on the output. A pulse of at least GLITCH_CYC + 3 cycles asserts reset.
- R5: With `delayMode` = 0, `mrN` held low asserts reset within 50 cycles (200 ns at 250 MHz).
- R6: With `delayMode` = 1, reset asserts only after `mrN` has stayed low for `holdUs` microseconds. Releasing `mrN` before then cancels the request and leaves the output unchanged.
- R7: Push-pull (`odMode` = 0) gives rstOe = 1 and rstN = NOT active. Open-drain (`odMode` = 1) gives rstN = 0 and rstOe = active, so the line is never driven high.
- R8: A new fault or a valid `mrN` press during the recovery window returns reset to active. The window then restarts from zero once the sources are good again.
- R9: While `arstN` is low, reset is active at once, independent of the clock. After `arstN` rises, a full recovery window must pass before the first release.
- R10: A channel whose `chEnable` bit is 0 is ignored. Its flag cannot assert reset.
- R11: In the delayed mode, a `holdUs` below 6 is treated as 6 µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock at CLK_HZ |
| arstN | input | 1 | Asynchronous clear, active low; forces reset active |
| faultIn | input | NCH | Supply-fault flags, 1 = rail below threshold (asynchronous) |
| chEnable | input | NCH | Per-channel enable mask, 1 = channel monitored (static) |
| mrN | input | 1 | Push-button reset, active low (asynchronous) |
| delayMode | input | 1 | 0 = glitch-filtered button, 1 = hold-time button |
| holdUs | input | HOLD_W | Hold time in µs for the delayed mode (minimum 6) |
| recSel | input | 2 | Recovery length select |
| odMode | input | 1 | 0 = push-pull output, 1 = open-drain output |
| rstN | output | 1 | Reset pin level, active low |
| rstOe | output | 1 | Reset pin output enable |

## Verification
The hardest situation to reach is a disturbance that lands deep inside the recovery window. The stimulus clears a fault, waits several hundred cycles into the count, and then applies a short fault pulse or a filtered button press. It then samples the output just before and just after one full window measured from the second clearance, so a count that resumes instead of restarting shows up as an early release. The delayed button mode is driven in the same way, with presses that end about 100 cycles before and after the hold threshold.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;

  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_RECOVER = 2'd1,
    ST_RUN     = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic recRun;
    logic recClr;
  } recStrobe_t;

endpackage

// File: rtl/rsq_sync.sv
`timescale 1ns/1ps
module rsq_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         arstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stage;
    always_ff @(posedge clk or negedge arstN) begin
      if (!arstN) stage <= {2{RST_VAL}};
      else        stage <= {stage[0], d[i]};
    end
    assign q[i] = stage[1];
  end

endmodule

// File: rtl/rsq_datapath.sv
`timescale 1ns/1ps
module rsq_datapath
  import rsq_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int CLK_HZ      = 250_000_000,
  parameter int REC0_US     = 13_200,
  parameter int REC1_US     = 210_000,
  parameter int REC2_US     = 900_000,
  parameter int GLITCH_NS   = 100,
  parameter int MIN_HOLD_US = 6,
  parameter int HOLD_W      = 16
) (
  input  logic              clk,
  input  logic              arstN,
  input  logic [NCH-1:0]    faultIn,
  input  logic [NCH-1:0]    chEnable,
  input  logic              mrN,
  input  logic              delayMode,
  input  logic [HOLD_W-1:0] holdUs,
  input  logic [1:0]        recSel,
  input  recStrobe_t        strb,
  output logic              faultAny,
  output logic              mrAct,
  output logic              recDone
);

  localparam int    CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int    REC0_CYC   = CYC_PER_US * REC0_US;
  localparam int    REC1_CYC   = CYC_PER_US * REC1_US;
  localparam int    REC2_CYC   = CYC_PER_US * REC2_US;
  localparam int    REC_MAX01  = (REC0_CYC > REC1_CYC) ? REC0_CYC : REC1_CYC;
  localparam int    REC_MAX    = (REC_MAX01 > REC2_CYC) ? REC_MAX01 : REC2_CYC;
  localparam int    REC_W      = $clog2(REC_MAX + 1);
  localparam longint GL_RAW    = (longint'(CLK_HZ) * longint'(GLITCH_NS) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int    GLITCH_CYC = (GL_RAW < 1) ? 1 : int'(GL_RAW);
  localparam int    CNT_W      = HOLD_W + $clog2(CYC_PER_US + 1) + 1;

  // ---------------- input synchronisers ----------------
  logic [NCH-1:0] faultS;
  logic [0:0]     mrNS;

  rsq_sync #(.W(NCH), .RST_VAL(1'b1)) uFaultSync (
    .clk(clk), .arstN(arstN), .d(faultIn), .q(faultS)
  );

  rsq_sync #(.W(1), .RST_VAL(1'b1)) uMrSync (
    .clk(clk), .arstN(arstN), .d(mrN), .q(mrNS)
  );

  assign faultAny = |(faultS & chEnable);

  // ---------------- button filter / hold-off ----------------
  logic              mrLowS;
  logic [HOLD_W-1:0] effUs;
  logic [CNT_W-1:0]  holdCyc;
  logic [CNT_W-1:0]  mrThr;
  logic [CNT_W-1:0]  mrCnt;

  assign mrLowS  = ~mrNS[0];
  assign effUs   = (holdUs < HOLD_W'(MIN_HOLD_US)) ? HOLD_W'(MIN_HOLD_US) : holdUs;
  assign holdCyc = CNT_W'(effUs) * CNT_W'(CYC_PER_US);
  assign mrThr   = delayMode ? holdCyc : CNT_W'(GLITCH_CYC);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)             mrCnt <= '0;
    else if (!mrLowS)       mrCnt <= '0;
    else if (mrCnt < mrThr) mrCnt <= mrCnt + CNT_W'(1);
  end

  assign mrAct = (mrCnt >= mrThr);

  // ---------------- recovery timer ----------------
  logic [REC_W-1:0] recLen;
  logic [REC_W-1:0] recCnt;

  always_comb begin
    case (recSel)
      2'd0:    recLen = REC_W'(REC0_CYC);
      2'd1:    recLen = REC_W'(REC1_CYC);
      default: recLen = REC_W'(REC2_CYC);
    endcase
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)           recCnt <= '0;
    else if (strb.recClr) recCnt <= '0;
    else if (strb.recRun) recCnt <= recCnt + REC_W'(1);
  end

  assign recDone = (recCnt >= recLen - REC_W'(1));

  // ---------------- assertions ----------------
  a_r8_disturb_restarts_count: assert property (@(posedge clk) disable iff (!arstN)
    (faultAny || mrAct) |=> (recCnt == '0));

  a_r6_early_release_cancels: assert property (@(posedge clk) disable iff (!arstN)
    !mrLowS |=> !mrAct);

  a_r4_accept_needs_low_input: assert property (@(posedge clk) disable iff (!arstN)
    $rose(mrAct) |-> $past(mrLowS));

endmodule

// File: rtl/rsq_control.sv
`timescale 1ns/1ps
module rsq_control
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       arstN,
  input  logic       faultAny,
  input  logic       mrAct,
  input  logic       recDone,
  output recStrobe_t strb,
  output logic       rstActive
);

  seqState_t state, stateNxt;
  logic      srcBad;

  assign srcBad = faultAny | mrAct;

  always_comb begin
    stateNxt = state;
    if (srcBad) begin
      stateNxt = ST_HOLD;
    end else begin
      case (state)
        ST_HOLD:    stateNxt = ST_RECOVER;
        ST_RECOVER: stateNxt = recDone ? ST_RUN : ST_RECOVER;
        ST_RUN:     stateNxt = ST_RUN;
        default:    stateNxt = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) state <= ST_HOLD;
    else        state <= stateNxt;
  end

  always_comb begin
    strb.recRun = (state == ST_RECOVER) && !srcBad;
    strb.recClr = !strb.recRun;
  end

  assign rstActive = (state != ST_RUN);

  // ---------------- assertions ----------------
  a_r1_source_forces_reset: assert property (@(posedge clk) disable iff (!arstN)
    (faultAny || mrAct) |=> rstActive);

  a_r2_release_needs_full_window: assert property (@(posedge clk) disable iff (!arstN)
    $fell(rstActive) |-> $past(recDone && !faultAny && !mrAct));

endmodule

// File: rtl/reset_sequencer.sv
`timescale 1ns/1ps
module reset_sequencer
  import rsq_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int CLK_HZ      = 250_000_000,
  parameter int REC0_US     = 13_200,
  parameter int REC1_US     = 210_000,
  parameter int REC2_US     = 900_000,
  parameter int GLITCH_NS   = 100,
  parameter int MIN_HOLD_US = 6,
  parameter int HOLD_W      = 16
) (
  input  logic              clk,
  input  logic              arstN,
  input  logic [NCH-1:0]    faultIn,
  input  logic [NCH-1:0]    chEnable,
  input  logic              mrN,
  input  logic              delayMode,
  input  logic [HOLD_W-1:0] holdUs,
  input  logic [1:0]        recSel,
  input  logic              odMode,
  output logic              rstN,
  output logic              rstOe
);

  recStrobe_t strb;
  logic       faultAny;
  logic       mrAct;
  logic       recDone;
  logic       rstActive;

  rsq_datapath #(
    .NCH(NCH), .CLK_HZ(CLK_HZ), .REC0_US(REC0_US), .REC1_US(REC1_US),
    .REC2_US(REC2_US), .GLITCH_NS(GLITCH_NS), .MIN_HOLD_US(MIN_HOLD_US),
    .HOLD_W(HOLD_W)
  ) uDatapath (
    .clk(clk), .arstN(arstN), .faultIn(faultIn), .chEnable(chEnable),
    .mrN(mrN), .delayMode(delayMode), .holdUs(holdUs), .recSel(recSel),
    .strb(strb), .faultAny(faultAny), .mrAct(mrAct), .recDone(recDone)
  );

  rsq_control uControl (
    .clk(clk), .arstN(arstN), .faultAny(faultAny), .mrAct(mrAct),
    .recDone(recDone), .strb(strb), .rstActive(rstActive)
  );

  // pin drive model
  assign rstOe = odMode ? rstActive : 1'b1;
  assign rstN  = odMode ? 1'b0 : ~rstActive;

endmodule

// File: tb/reset_sequencer_test.sv
`timescale 1ns/1ps
module reset_sequencer_test;

  localparam int REC0 = 500;   // 2 us at 250 MHz
  localparam int REC1 = 1250;  // 5 us
  localparam int REC2 = 2000;  // 8 us

  logic        clk = 1'b0;
  logic        arstN;
  logic [2:0]  faultIn;
  logic [2:0]  chEnable;
  logic        mrN;
  logic        delayMode;
  logic [15:0] holdUs;
  logic [1:0]  recSel;
  logic        odMode;
  logic        rstN;
  logic        rstOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  reset_sequencer #(
    .NCH(3), .CLK_HZ(250_000_000), .REC0_US(2), .REC1_US(5), .REC2_US(8),
    .GLITCH_NS(100), .MIN_HOLD_US(6), .HOLD_W(16)
  ) uut (
    .clk(clk), .arstN(arstN), .faultIn(faultIn), .chEnable(chEnable),
    .mrN(mrN), .delayMode(delayMode), .holdUs(holdUs), .recSel(recSel),
    .odMode(odMode), .rstN(rstN), .rstOe(rstOe)
  );

  // en[9:7] flt[6:4] mr[3] od[2] expN[1] expOe[0]
  localparam logic [9:0] VEC [0:8] = '{
    10'b111_000_1_0_1_1,
    10'b111_001_1_0_0_1,
    10'b111_100_1_1_0_1,
    10'b110_001_1_0_1_1,
    10'b011_100_1_0_1_1,
    10'b111_000_0_0_0_1,
    10'b111_000_1_1_0_0,
    10'b010_010_1_1_0_1,
    10'b000_111_1_0_1_1
  };

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic watchHigh(input int n, output logic ok);
    ok = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (rstN !== 1'b1) ok = 1'b0;
    end
  endtask

  task automatic recTest(input logic [1:0] sel, input int len, input string tag);
    recSel = sel;
    faultIn[1] = 1'b1;
    waitCyc(10);
    chk({tag, " R1 fault asserts within 10 cycles"}, rstN, 1'b0);
    faultIn[1] = 1'b0;
    waitCyc(len - 10);
    chk({tag, " still held just before window"}, rstN, 1'b0);
    waitCyc(20);
    chk({tag, " released just after window"}, rstN, 1'b1);
  endtask

  initial begin
    waitCyc(150_000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ok;
    arstN = 1'b0; faultIn = 3'b000; chEnable = 3'b111; mrN = 1'b1;
    delayMode = 1'b0; holdUs = 16'd10; recSel = 2'd0; odMode = 1'b0;
    waitCyc(3);
    chk("R9 reset state rstN", rstN, 1'b0);
    chk("R9 reset state rstOe", rstOe, 1'b1);
    arstN = 1'b1;
    waitCyc(490);
    chk("R9 full window after clear (early)", rstN, 1'b0);
    waitCyc(30);
    chk("R9 R2 first release", rstN, 1'b1);

    // table of static patterns: R1 R7 R10
    for (int i = 0; i < 9; i++) begin
      chEnable = VEC[i][9:7];
      faultIn  = VEC[i][6:4];
      mrN      = VEC[i][3];
      odMode   = VEC[i][2];
      waitCyc(600);
      chk($sformatf("R1 R7 R10 vector %0d rstN", i), rstN, VEC[i][1]);
      chk($sformatf("R7 vector %0d rstOe", i), rstOe, VEC[i][0]);
    end
    chEnable = 3'b111; faultIn = 3'b000; mrN = 1'b1; odMode = 1'b0;
    waitCyc(600);
    chk("R2 back to released", rstN, 1'b1);

    // R3 recovery select
    recTest(2'd0, REC0, "R3 sel0");
    recTest(2'd1, REC1, "R3 sel1");
    recTest(2'd2, REC2, "R3 sel2");
    recTest(2'd3, REC2, "R3 sel3");
    recSel = 2'd0;

    // R8 restart on fault during window
    faultIn[0] = 1'b1; waitCyc(10); faultIn[0] = 1'b0;
    waitCyc(300);
    faultIn[2] = 1'b1; waitCyc(3); faultIn[2] = 1'b0;
    waitCyc(REC0 - 10);
    chk("R8 fault restart keeps reset (early)", rstN, 1'b0);
    waitCyc(20);
    chk("R8 fault restart release", rstN, 1'b1);

    // R8 restart on button during window
    faultIn[0] = 1'b1; waitCyc(10); faultIn[0] = 1'b0;
    waitCyc(300);
    mrN = 1'b0; waitCyc(40); mrN = 1'b1;
    waitCyc(REC0 - 10);
    chk("R8 button restart keeps reset (early)", rstN, 1'b0);
    waitCyc(20);
    chk("R8 button restart release", rstN, 1'b1);

    // R4 glitch filter
    mrN = 1'b0; waitCyc(24); mrN = 1'b1;
    watchHigh(600, ok);
    chk("R4 24-cycle pulse ignored", ok, 1'b1);
    mrN = 1'b0; waitCyc(30); mrN = 1'b1;
    chk("R4 30-cycle pulse accepted", rstN, 1'b0);
    waitCyc(600);
    chk("R4 release after accepted pulse", rstN, 1'b1);

    // R5 latency
    mrN = 1'b0; waitCyc(50);
    chk("R5 held button asserts within 50 cycles", rstN, 1'b0);
    mrN = 1'b1; waitCyc(600);

    // R6 delayed mode, 10 us = 2500 cycles
    delayMode = 1'b1; holdUs = 16'd10;
    mrN = 1'b0; watchHigh(2000, ok); mrN = 1'b1;
    chk("R6 short hold no reset", ok, 1'b1);
    waitCyc(10);
    chk("R6 cancelled request", rstN, 1'b1);
    mrN = 1'b0; waitCyc(2400);
    chk("R6 before hold threshold", rstN, 1'b1);
    waitCyc(160);
    chk("R6 after hold threshold", rstN, 1'b0);
    mrN = 1'b1; waitCyc(600);

    // R11 hold clamp: 2 us treated as 6 us = 1500 cycles
    holdUs = 16'd2;
    mrN = 1'b0; waitCyc(1400);
    chk("R11 clamped hold not yet reached", rstN, 1'b1);
    waitCyc(160);
    chk("R11 clamped hold reached", rstN, 1'b0);
    mrN = 1'b1; delayMode = 1'b0; waitCyc(600);

    // R9 asynchronous clear mid-run
    chk("R9 released before clear", rstN, 1'b1);
    #1 arstN = 1'b0;
    #0.5;
    chk("R9 async clear asserts at once", rstN, 1'b0);
    waitCyc(2);
    arstN = 1'b1;
    waitCyc(490);
    chk("R9 full window after mid-run clear", rstN, 1'b0);
    waitCyc(30);
    chk("R9 release after mid-run clear", rstN, 1'b1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule